// File: doc/BRIEF.md
# Pointer Register Address Unit

This unit produces data-RAM addresses for a 16-bit signal processor. It holds eight 8-bit pointer registers in two groups of four. Each group serves one of two 256-word RAM banks. An access names a pointer through a bank bit and a 2-bit select. A 2-bit modifier then says how the pointer changes after the access: it is left alone, incremented, or decremented. The increment and the decrement can be restricted to a power-of-two window, which is set by a 3-bit loop-size field. The address driven to the RAM is always the pointer value from before the update. The updated pointer is registered on the same clock edge.

The last pointer of each group (select 3) is not stored. An access through it uses the modifier value 0–3 as a fixed address in its bank. A second indirection level is also available. In that mode the RAM word at the pointer address becomes a program-memory address, and the unit asks for the RAM word to be written back incremented by one. Pointers can also be loaded from a load-immediate instruction word or from a plain register write. Those loads take priority over a post-modify that targets the same pointer in the same cycle.

Top module: `ptr_addr_unit`

## Requirements
- R1: On an access, `mem_bank` equals `acc_bank` and `mem_addr` equals the selected pointer's value before any update. The pointer index is {`acc_bank`, `acc_sel`}.
- R2: With `acc_sel` = 3, `mem_addr` equals `acc_mod` (0–3) in the chosen bank and nothing is stored. Loads aimed at index 3 or 7 are ignored.
- R3: Modifier 00 leaves the pointer unchanged.
- R4: Modifier 01 adds one across all 8 bits (255 wraps to 0) and ignores `loop_n`.
- R5: Modifier 10 subtracts one. When `loop_n` = N is non-zero, only the low N bits wrap and the upper bits are kept.
- R6: Modifier 11 adds one. When `loop_n` = N is non-zero, only the low N bits wrap and the upper 8−N bits are kept.
- R7: When `loop_n` = 0, modifiers 10 and 11 step across all 8 bits.
- R8: A second-level access (`acc_deep` = 1) with modifier 00, or one through select 3, does the following in the same cycle: it raises `pm_vld`, drives `pm_addr` = `mem_rdata`, raises `mem_wb_en` and drives `mem_wb_data` = `mem_rdata` + 1 modulo 2^16. The pointer does not change.
- R9: A second-level access on a stored pointer with a non-zero modifier is invalid. `pm_vld`, `pm_addr`, `mem_wb_en` and `mem_en` are all zero, and the pointer does not change.
- R10: `imm_vld` loads pointer `imm_op[10:8]` with `imm_op[7:0]`.
- R11: `wr_vld` loads pointer `wr_idx` with `wr_val`. When several updates target one pointer in the same cycle, the immediate load wins over the register write, and the register write wins over the post-modify.
- R12: Reset clears every pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access request |
| acc_deep | input | 1 | Second indirection level |
| acc_bank | input | 1 | Bank bit (pointer group) |
| acc_sel | input | 2 | Pointer select in group |
| acc_mod | input | 2 | Modifier / fixed address |
| loop_n | input | 3 | Loop-size field |
| mem_rdata | input | 16 | RAM word at `mem_addr` |
| imm_vld | input | 1 | Load-immediate request |
| imm_op | input | 11 | Index in 10:8, value in 7:0 |
| wr_vld | input | 1 | Register-write request |
| wr_idx | input | 3 | Register-write index |
| wr_val | input | 8 | Register-write value |
| mem_bank | output | 1 | Selected RAM bank |
| mem_addr | output | 8 | RAM word address |
| mem_en | output | 1 | Valid RAM access |
| mem_wb_en | output | 1 | Write-back of incremented word |
| mem_wb_data | output | 16 | Incremented RAM word |
| pm_vld | output | 1 | Program-memory request |
| pm_addr | output | 16 | Program-memory address |

## Verification
A post-modify and a pointer load can land on the same register in the same cycle. The bench provokes this by raising an incrementing access together with an immediate load, and an immediate load together with a register write. It also raises a register write together with an incrementing access. In each case it reads the pointer back on the following cycle with a modifier-00 access and compares it against the priority order in R11. It also checks that the access in the collision cycle still reported the old pointer value.

// File: rtl/ptr_au_pkg.sv
package ptr_au_pkg;
    typedef enum logic [1:0] {
        MOD_KEEP     = 2'b00,
        MOD_INC_RAW  = 2'b01,
        MOD_DEC      = 2'b10,
        MOD_INC_LOOP = 2'b11
    } ptr_mod_e;

    localparam int DEF_PTR_W  = 8;
    localparam int DEF_WORD_W = 16;
    localparam int DEF_SEL_W  = 2;
    localparam int DEF_LOOP_W = 3;
endpackage

// File: rtl/ptr_au_decode.sv
module ptr_au_decode
    import ptr_au_pkg::*;
#(
    parameter int PTR_W = DEF_PTR_W,
    parameter int SEL_W = DEF_SEL_W,
    localparam int IDX_W = SEL_W + 1
) (
    input  logic             bank,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       mod,
    input  logic             deep,
    output logic [IDX_W-1:0] idx,
    output logic             fixed,
    output logic [PTR_W-1:0] fixed_addr,
    output logic             bad_deep
);
    always_comb begin
        idx        = {bank, sel};
        fixed      = &sel;
        fixed_addr = PTR_W'(mod);
        bad_deep   = deep && !fixed && (mod != 2'b00);
    end
endmodule

// File: rtl/ptr_au_step.sv
module ptr_au_step
    import ptr_au_pkg::*;
#(
    parameter int PTR_W  = DEF_PTR_W,
    parameter int LOOP_W = DEF_LOOP_W
) (
    input  logic [PTR_W-1:0]  cur,
    input  ptr_mod_e          mod,
    input  logic [LOOP_W-1:0] loop_n,
    output logic [PTR_W-1:0]  nxt
);
    logic [PTR_W-1:0] wmask;
    logic [PTR_W-1:0] inc_v;
    logic [PTR_W-1:0] dec_v;

    always_comb begin
        // window mask: all ones when no loop size is set
        if (loop_n == '0) wmask = '1;
        else              wmask = (PTR_W'(1) << loop_n) - PTR_W'(1);
        inc_v = cur + PTR_W'(1);
        dec_v = cur - PTR_W'(1);
        unique case (mod)
            MOD_KEEP:     nxt = cur;
            MOD_INC_RAW:  nxt = inc_v;
            MOD_DEC:      nxt = (cur & ~wmask) | (dec_v & wmask);
            MOD_INC_LOOP: nxt = (cur & ~wmask) | (inc_v & wmask);
            default:      nxt = cur;
        endcase
    end
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
    import ptr_au_pkg::*;
#(
    parameter int PTR_W  = DEF_PTR_W,
    parameter int WORD_W = DEF_WORD_W,
    parameter int SEL_W  = DEF_SEL_W,
    parameter int LOOP_W = DEF_LOOP_W,
    localparam int IDX_W = SEL_W + 1,
    localparam int N_PTR = 1 << IDX_W,
    localparam int GRP   = 1 << SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_vld,
    input  logic                   acc_deep,
    input  logic                   acc_bank,
    input  logic [SEL_W-1:0]       acc_sel,
    input  logic [1:0]             acc_mod,
    input  logic [LOOP_W-1:0]      loop_n,
    input  logic [WORD_W-1:0]      mem_rdata,
    input  logic                   imm_vld,
    input  logic [IDX_W+PTR_W-1:0] imm_op,
    input  logic                   wr_vld,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [PTR_W-1:0]       wr_val,
    output logic                   mem_bank,
    output logic [PTR_W-1:0]       mem_addr,
    output logic                   mem_en,
    output logic                   mem_wb_en,
    output logic [WORD_W-1:0]      mem_wb_data,
    output logic                   pm_vld,
    output logic [WORD_W-1:0]      pm_addr
);
    typedef logic [N_PTR-1:0][PTR_W-1:0] ptr_arr_t;
    typedef struct packed {
        ptr_arr_t ptr;
    } au_state_t;

    au_state_t st_d, st_q;

    logic [IDX_W-1:0] acc_idx;
    logic             acc_fixed;
    logic [PTR_W-1:0] fixed_addr;
    logic             bad_deep;
    logic [PTR_W-1:0] cur_ptr;
    logic [PTR_W-1:0] step_ptr;
    logic             step_en;
    logic             deep_ok;
    logic [IDX_W-1:0] imm_idx;
    logic [PTR_W-1:0] imm_val;
    logic [N_PTR*PTR_W-1:0] ptr_flat;

    ptr_au_decode #(.PTR_W(PTR_W), .SEL_W(SEL_W)) u_dec (
        .bank       (acc_bank),
        .sel        (acc_sel),
        .mod        (acc_mod),
        .deep       (acc_deep),
        .idx        (acc_idx),
        .fixed      (acc_fixed),
        .fixed_addr (fixed_addr),
        .bad_deep   (bad_deep)
    );

    assign cur_ptr = st_q.ptr[acc_idx];

    ptr_au_step #(.PTR_W(PTR_W), .LOOP_W(LOOP_W)) u_step (
        .cur    (cur_ptr),
        .mod    (ptr_mod_e'(acc_mod)),
        .loop_n (loop_n),
        .nxt    (step_ptr)
    );

    assign imm_idx  = imm_op[PTR_W +: IDX_W];
    assign imm_val  = imm_op[PTR_W-1:0];
    assign ptr_flat = st_q.ptr;

    // next-state: immediate load > register write > post-modify
    always_comb begin
        st_d    = st_q;
        step_en = acc_vld && !acc_deep && !acc_fixed;
        for (int i = 0; i < N_PTR; i++) begin
            if ((i % GRP) == GRP - 1) begin
                st_d.ptr[i] = '0;
            end else if (imm_vld && imm_idx == IDX_W'(i)) begin
                st_d.ptr[i] = imm_val;
            end else if (wr_vld && wr_idx == IDX_W'(i)) begin
                st_d.ptr[i] = wr_val;
            end else if (step_en && acc_idx == IDX_W'(i)) begin
                st_d.ptr[i] = step_ptr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        deep_ok     = acc_vld && acc_deep && !bad_deep;
        mem_bank    = acc_bank;
        mem_addr    = acc_fixed ? fixed_addr : cur_ptr;
        mem_en      = acc_vld && !bad_deep;
        pm_vld      = deep_ok;
        pm_addr     = deep_ok ? mem_rdata : '0;
        mem_wb_en   = deep_ok;
        mem_wb_data = mem_rdata + WORD_W'(1);
    end
endmodule

// File: rtl/ptr_au_chk.sv
module ptr_au_chk #(
    parameter int PTR_W  = 8,
    parameter int WORD_W = 16,
    parameter int SEL_W  = 2,
    localparam int IDX_W = SEL_W + 1,
    localparam int N_PTR = 1 << IDX_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acc_vld,
    input logic                   acc_deep,
    input logic                   acc_bank,
    input logic [SEL_W-1:0]       acc_sel,
    input logic [1:0]             acc_mod,
    input logic [WORD_W-1:0]      mem_rdata,
    input logic                   imm_vld,
    input logic                   wr_vld,
    input logic [PTR_W-1:0]       mem_addr,
    input logic                   mem_wb_en,
    input logic [WORD_W-1:0]      mem_wb_data,
    input logic                   pm_vld,
    input logic [WORD_W-1:0]      pm_addr,
    input logic [N_PTR*PTR_W-1:0] ptr_flat
);
    logic [IDX_W-1:0] idx_q;
    logic [PTR_W-1:0] ptr_prev_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= {acc_bank, acc_sel};
    end
    assign ptr_prev_idx = ptr_flat[idx_q*PTR_W +: PTR_W];

    // R2: fixed pointer addresses with the modifier value
    a_r2_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && (&acc_sel)) |-> (mem_addr == PTR_W'(acc_mod)));

    // R3: keep modifier, no loads -> no pointer changes
    a_r3_keep_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_mod == 2'b00 && !imm_vld && !wr_vld) |=> (ptr_flat == $past(ptr_flat)));

    // R4: raw increment lands one above the address used
    a_r4_raw_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_deep && !(&acc_sel) && acc_mod == 2'b01 && !imm_vld && !wr_vld)
        |=> (ptr_prev_idx == $past(mem_addr) + PTR_W'(1)));

    // R8: write-back is the read word plus one, alongside a program request
    a_r8_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wb_en |-> (pm_vld && pm_addr == mem_rdata && mem_wb_data == mem_rdata + WORD_W'(1)));

    // R9: invalid second-level access yields nothing
    a_r9_invalid_deep: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_deep && !(&acc_sel) && acc_mod != 2'b00)
        |-> (!pm_vld && pm_addr == '0 && !mem_wb_en));
endmodule

bind ptr_addr_unit ptr_au_chk #(.PTR_W(PTR_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_vld     (acc_vld),
    .acc_deep    (acc_deep),
    .acc_bank    (acc_bank),
    .acc_sel     (acc_sel),
    .acc_mod     (acc_mod),
    .mem_rdata   (mem_rdata),
    .imm_vld     (imm_vld),
    .wr_vld      (wr_vld),
    .mem_addr    (mem_addr),
    .mem_wb_en   (mem_wb_en),
    .mem_wb_data (mem_wb_data),
    .pm_vld      (pm_vld),
    .pm_addr     (pm_addr),
    .ptr_flat    (ptr_flat)
);

// File: tb/sim_ptr_addr_unit.sv
`timescale 1ns/1ps
module sim_ptr_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_vld, acc_deep, acc_bank;
    logic [1:0]  acc_sel, acc_mod;
    logic [2:0]  loop_n;
    logic [15:0] mem_rdata;
    logic        imm_vld;
    logic [10:0] imm_op;
    logic        wr_vld;
    logic [2:0]  wr_idx;
    logic [7:0]  wr_val;
    logic        mem_bank, mem_en, mem_wb_en, pm_vld;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wb_data, pm_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ptr_addr_unit u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        acc_vld = 0; acc_deep = 0; acc_bank = 0; acc_sel = 0; acc_mod = 0;
        loop_n = 0; mem_rdata = 0; imm_vld = 0; imm_op = 0;
        wr_vld = 0; wr_idx = 0; wr_val = 0;
    endtask

    task automatic next();
        @(negedge clk);
        idle();
    endtask

    task automatic acc(input logic deep, input logic b, input logic [1:0] s,
                       input logic [1:0] m, input logic [2:0] l);
        acc_vld = 1; acc_deep = deep; acc_bank = b; acc_sel = s; acc_mod = m; loop_n = l;
    endtask

    task automatic peek(input string tag, input logic b, input logic [1:0] s, input logic [7:0] exp);
        acc(0, b, s, 2'b00, 3'd0);
        #1 chk(tag, mem_addr, exp);
        next();
    endtask

    // {bank, sel, mod, loop, expected addr, requirement}
    typedef struct packed {
        logic       b;
        logic [1:0] s;
        logic [1:0] m;
        logic [2:0] l;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VEC [17] = '{
        '{1'b0, 2'd0, 2'b00, 3'd0, 8'h2E, 4'd3},  // R3
        '{1'b0, 2'd0, 2'b00, 3'd0, 8'h2E, 4'd3},  // R3 unchanged
        '{1'b0, 2'd0, 2'b11, 3'd0, 8'h2E, 4'd7},  // R7 plain inc
        '{1'b0, 2'd0, 2'b01, 3'd2, 8'h2F, 4'd4},  // R4 ignores loop
        '{1'b0, 2'd0, 2'b10, 3'd0, 8'h30, 4'd5},  // R5
        '{1'b0, 2'd0, 2'b11, 3'd2, 8'h2F, 4'd6},  // R6 wrap 4
        '{1'b0, 2'd0, 2'b10, 3'd2, 8'h2C, 4'd5},  // R5 wrap down
        '{1'b0, 2'd0, 2'b11, 3'd4, 8'h2F, 4'd6},  // R6 wrap 16
        '{1'b0, 2'd0, 2'b00, 3'd0, 8'h20, 4'd6},
        '{1'b1, 2'd1, 2'b01, 3'd0, 8'hFF, 4'd4},  // R4 8-bit wrap
        '{1'b1, 2'd1, 2'b11, 3'd7, 8'h00, 4'd6},
        '{1'b1, 2'd1, 2'b10, 3'd0, 8'h01, 4'd5},
        '{1'b1, 2'd1, 2'b10, 3'd0, 8'h00, 4'd7},  // R7 plain dec wrap
        '{1'b1, 2'd1, 2'b00, 3'd0, 8'hFF, 4'd7},
        '{1'b0, 2'd3, 2'b10, 3'd0, 8'h02, 4'd2},  // R2
        '{1'b1, 2'd3, 2'b01, 3'd0, 8'h01, 4'd2},  // R2
        '{1'b0, 2'd2, 2'b00, 3'd0, 8'h10, 4'd11}  // R11 register write
    };

    initial begin
        #250000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R12 reset state
        for (int i = 0; i < 8; i++) begin
            if (i % 4 != 3) peek($sformatf("R12 reset ptr%0d", i), i[2], i[1:0], 8'h00);
        end

        // R10 immediate loads, R11 register write
        imm_vld = 1; imm_op = {3'd0, 8'h2E}; next();
        imm_vld = 1; imm_op = {3'd5, 8'hFF}; next();
        wr_vld = 1; wr_idx = 3'd2; wr_val = 8'h10; next();

        foreach (VEC[k]) begin
            acc(0, VEC[k].b, VEC[k].s, VEC[k].m, VEC[k].l);
            #1;
            chk($sformatf("R1 vec%0d (req R%0d) addr", k, VEC[k].req), mem_addr, VEC[k].exp);
            chk($sformatf("R1 vec%0d bank", k), mem_bank, VEC[k].b);
            chk($sformatf("R1 vec%0d en", k), mem_en, 1'b1);
            next();
        end

        // R8 second level on ptr2 = 0x10
        acc(1, 0, 2'd2, 2'b00, 3'd0); mem_rdata = 16'h1234;
        #1 chk("R8 addr", mem_addr, 8'h10);
        chk("R8 pm_vld", pm_vld, 1'b1);
        chk("R8 pm_addr", pm_addr, 16'h1234);
        chk("R8 wb_en", mem_wb_en, 1'b1);
        chk("R8 wb_data", mem_wb_data, 16'h1235);
        next();
        acc(1, 1, 2'd3, 2'b10, 3'd0); mem_rdata = 16'hFFFF;
        #1 chk("R8 fixed addr", mem_addr, 8'h02);
        chk("R8 fixed pm_addr", pm_addr, 16'hFFFF);
        chk("R8 wrap wb", mem_wb_data, 16'h0000);
        next();
        peek("R8 ptr unchanged", 0, 2'd2, 8'h10);

        // R9 invalid second level
        acc(1, 0, 2'd2, 2'b01, 3'd0); mem_rdata = 16'hABCD;
        #1 chk("R9 pm_vld", pm_vld, 1'b0);
        chk("R9 pm_addr", pm_addr, 16'h0000);
        chk("R9 wb_en", mem_wb_en, 1'b0);
        chk("R9 mem_en", mem_en, 1'b0);
        next();
        peek("R9 ptr unchanged", 0, 2'd2, 8'h10);

        // R11 collisions (ptr0 is 0x20)
        acc(0, 0, 2'd0, 2'b01, 3'd0); imm_vld = 1; imm_op = {3'd0, 8'h55};
        #1 chk("R11 old addr in collision", mem_addr, 8'h20);
        next();
        peek("R11 imm over step", 0, 2'd0, 8'h55);
        imm_vld = 1; imm_op = {3'd0, 8'h77}; wr_vld = 1; wr_idx = 3'd0; wr_val = 8'h66; next();
        peek("R11 imm over write", 0, 2'd0, 8'h77);
        acc(0, 0, 2'd1, 2'b01, 3'd0); wr_vld = 1; wr_idx = 3'd1; wr_val = 8'h40; next();
        peek("R11 write over step", 0, 2'd1, 8'h40);

        // R2 load to fixed pointer ignored
        wr_vld = 1; wr_idx = 3'd3; wr_val = 8'h99; next();
        imm_vld = 1; imm_op = {3'd7, 8'h99}; next();
        peek("R2 fixed after write", 0, 2'd3, 8'h00);
        acc(0, 1, 2'd3, 2'b11, 3'd0);
        #1 chk("R2 fixed after imm", mem_addr, 8'h03);
        next();

        // R12 reset mid-run
        rst_n = 0; next(); next(); rst_n = 1;
        peek("R12 mid-run reset", 0, 2'd0, 8'h00);
        peek("R12 mid-run reset ptr5", 1, 2'd1, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule